// File: doc/BRIEF.md
# Coarse Pulsewidth Range Identifier

This block sits beside a sixteen-tap coarse delay line and tells the rest of a digital pulsewidth measurement loop which quarter of the line the reference pulse reached. The line's state comes in as a thermometer vector. Entry 0 is the line input, and entry k (1..15) is high while the pulse is present at the output of cell k. Cell sixteen is a matching load and is not tapped. Only the entries at 4, 8 and 12 are sampled, each into its own flip-flop, while the reference pulse is high.

When the reference pulse falls, the block decodes the last samples into a one-hot range code and raises a done flag. From then on the result stays frozen until reset. The range code drives a 16-to-4 window multiplexer, so later detectors only need to look at four taps. It also drives per-group enables that switch off the delay groups beyond the chosen window.

If the pulse outlives the whole line, the result saturates to the top range and an overflow flag is set.

Top module: `pw_range_ident`

## Requirements
- R1: After a synchronous active-low reset, `range_code` is 4'b1000, `done` is 0, `overflow` is 0, `win_sel` is 0 and `grp_en` is 4'b1111.
- R2: `range_code` bit 3 means range 0 (pulse below 4 cells), bit 2 range 1 (4 to 8), bit 1 range 2 (8 to 12) and bit 0 range 3 (12 or more). The range is 0 when none of `line[4]`, `line[8]`, `line[12]` was high, and otherwise one more than the index of the highest high tap among them (1 for tap 4, 2 for tap 8, 3 for tap 12), whatever the lower taps were.
- R3: If `line[15]` was high in the last sampled cycle, the result is range 3 (4'b0001) and `overflow` is 1; otherwise `overflow` is 0.
- R4: The result is taken at the first clock edge at which `ref_pulse` is low after having been high on the previous edge. `done` rises on that same edge. Afterwards `range_code`, `overflow` and `done` hold until reset, whatever `ref_pulse` and `line` do.
- R5: The taps are sampled only on edges where `ref_pulse` is high. The values from the last such edge decide the result, and `line` values on the falling edge itself are ignored.
- R6: `win_sel` is the range index (0 to 3), and `win_taps` equals `line[4*win_sel+3 : 4*win_sel]`.
- R7: `grp_en` bit g enables delay group g (group 0 = cells 1-3, 1 = cells 4-7, 2 = cells 8-11, 3 = cells 12-15). All are 1 while `done` is 0. Once `done` is 1, exactly bits 0 up to `win_sel` are 1.
- R8: `range_code` always has exactly one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset; restarts a measurement |
| ref_pulse | input | 1 | Reference pulse being measured |
| line | input | 16 | Thermometer state of the delay line, entry 0 = line input |
| range_code | output | 4 | One-hot coarse range, bit 3 = shortest |
| done | output | 1 | Measurement finished, result frozen |
| overflow | output | 1 | Pulse outlasted the whole line |
| win_sel | output | 2 | Window select for the 16-to-4 tap multiplexer |
| win_taps | output | 4 | The four line taps of the selected window |
| grp_en | output | 4 | Per-group delay-cell enables |

## Verification
The bench targets the range borders: a pulse that reaches tap 4 but not 8, one that reaches 12 but not the last cell, and one that fills the line. A decoder that is off by one tap would report a neighbouring range at those borders. It also feeds a non-thermometer pattern, which a design that prioritises the lowest tap would misread. It drives a full line during the falling cycle and a second pulse after completion; sampling at the wrong edge, or failing to freeze, would corrupt the result. Finally it checks that a reset in mid-measurement discards the partial samples, and that the group enables fall back to a thermometer up to the window, since a wrong mask would leave the selected taps unpowered.

// File: rtl/pw_range_pkg.sv
// Shared sizing for the coarse pulsewidth range identifier.
// Assumes the line length divides evenly into the group count.
package pw_range_pkg;
    localparam int unsigned NUM_TAPS   = 16;
    localparam int unsigned NUM_GROUPS = 4;
    localparam int unsigned GROUP_LEN  = NUM_TAPS / NUM_GROUPS;
    localparam int unsigned SEL_W      = $clog2(NUM_GROUPS);
    typedef logic [NUM_GROUPS-1:0] range_t;
endpackage

// File: rtl/pw_tap_sampler.sv
// Samples the group-boundary taps and the last line cell while the
// reference is high, and flags the reference falling edge.
// Assumes ref_pulse and line are synchronous to clk.
module pw_tap_sampler #(
    parameter int unsigned NUM_TAPS   = 16,
    parameter int unsigned NUM_GROUPS = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ref_pulse,
    input  logic [NUM_TAPS-1:0]   line,
    input  logic                  frozen,
    output logic [NUM_GROUPS-2:0] tap_q,
    output logic                  last_q,
    output logic                  fall
);
    localparam int unsigned GROUP_LEN = NUM_TAPS / NUM_GROUPS;

    logic ref_q;

    // Remember the reference level of the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) ref_q <= 1'b0;
        else        ref_q <= ref_pulse;
    end

    assign fall = ref_q && !ref_pulse && !frozen;

    // One flip-flop per boundary tap, loaded while the pulse is high.
    for (genvar t = 1; t < NUM_GROUPS; t++) begin : g_tap
        always_ff @(posedge clk) begin
            if (!rst_n)                    tap_q[t-1] <= 1'b0;
            else if (ref_pulse && !frozen) tap_q[t-1] <= line[t*GROUP_LEN];
        end
    end

    // Overflow sample of the last tapped cell.
    always_ff @(posedge clk) begin
        if (!rst_n)                    last_q <= 1'b0;
        else if (ref_pulse && !frozen) last_q <= line[NUM_TAPS-1];
    end

    // R5: samples hold while the reference is low
    assert_hold_when_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_pulse |=> $stable(tap_q) && $stable(last_q));
    // R4: samples hold once frozen
    assert_hold_when_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        frozen |=> $stable(tap_q));
endmodule

// File: rtl/pw_range_encoder.sv
// Turns the last tap samples into a frozen one-hot range, done flag and
// overflow flag at the reference falling edge.
// Assumes tap samples are thermometer-like; the highest high tap wins.
module pw_range_encoder #(
    parameter int unsigned NUM_GROUPS = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  fall,
    input  logic [NUM_GROUPS-2:0] tap_q,
    input  logic                  last_q,
    output logic [NUM_GROUPS-1:0] range_code,
    output logic                  done,
    output logic                  overflow
);
    logic [NUM_GROUPS-1:0] next_code;

    // Priority decode: highest sampled tap picks the range, overflow saturates.
    always_comb begin
        next_code = '0;
        next_code[NUM_GROUPS-1] = 1'b1;
        for (int t = 0; t < NUM_GROUPS-1; t++) begin
            if (tap_q[t]) begin
                next_code = '0;
                next_code[NUM_GROUPS-2-t] = 1'b1;
            end
        end
        if (last_q) begin
            next_code = '0;
            next_code[0] = 1'b1;
        end
    end

    // Capture once at the falling edge, then hold until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            range_code <= '0;
            range_code[NUM_GROUPS-1] <= 1'b1;
            done     <= 1'b0;
            overflow <= 1'b0;
        end else if (fall && !done) begin
            range_code <= next_code;
            done       <= 1'b1;
            overflow   <= last_q;
        end
    end

    // R8: one-hot range at all times
    assert_onehot_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(range_code) == 1);
    // R4: result frozen after done
    assert_frozen_result_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done && $stable(range_code) && $stable(overflow));
    // R3: overflow forces the top range
    assert_overflow_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> range_code[0]);
endmodule

// File: rtl/pw_window_ctrl.sv
// Derives the 16-to-4 window select, the selected taps and the delay
// group enables from the range code. Purely combinational.
module pw_window_ctrl #(
    parameter int unsigned NUM_TAPS   = 16,
    parameter int unsigned NUM_GROUPS = 4,
    parameter int unsigned SEL_W      = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_GROUPS-1:0]         range_code,
    input  logic                          done,
    input  logic [NUM_TAPS-1:0]           line,
    output logic [SEL_W-1:0]              win_sel,
    output logic [NUM_TAPS/NUM_GROUPS-1:0] win_taps,
    output logic [NUM_GROUPS-1:0]         grp_en
);
    localparam int unsigned GROUP_LEN = NUM_TAPS / NUM_GROUPS;

    // One-hot to index: bit NUM_GROUPS-1 is window 0.
    always_comb begin
        win_sel = '0;
        for (int b = 0; b < NUM_GROUPS; b++) begin
            if (range_code[b]) win_sel = SEL_W'(NUM_GROUPS - 1 - b);
        end
    end

    // Tap window multiplexer.
    assign win_taps = line[win_sel*GROUP_LEN +: GROUP_LEN];

    // Keep groups up to the window powered; all on before done.
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_en
        assign grp_en[g] = !done || (g <= int'(win_sel));
    end

    // R7: the selected window's group is always powered
    assert_window_powered_R7: assert property (@(posedge clk) disable iff (!rst_n)
        grp_en[win_sel]);
    // R7: full line powered until done
    assert_all_on_before_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> &grp_en);
endmodule

// File: rtl/pw_range_ident.sv
// Top of the coarse pulsewidth range identifier: samples three boundary
// taps of a 16-entry thermometer line, freezes a one-hot range at the
// reference falling edge, and drives the tap window and group enables.
module pw_range_ident (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ref_pulse,
    input  logic [15:0] line,
    output logic [3:0]  range_code,
    output logic        done,
    output logic        overflow,
    output logic [1:0]  win_sel,
    output logic [3:0]  win_taps,
    output logic [3:0]  grp_en
);
    import pw_range_pkg::*;

    logic [NUM_GROUPS-2:0] tap_q;
    logic                  last_q;
    logic                  fall;

    pw_tap_sampler #(.NUM_TAPS(NUM_TAPS), .NUM_GROUPS(NUM_GROUPS)) u_sampler (
        .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .line(line),
        .frozen(done), .tap_q(tap_q), .last_q(last_q), .fall(fall)
    );

    pw_range_encoder #(.NUM_GROUPS(NUM_GROUPS)) u_encoder (
        .clk(clk), .rst_n(rst_n), .fall(fall), .tap_q(tap_q), .last_q(last_q),
        .range_code(range_code), .done(done), .overflow(overflow)
    );

    pw_window_ctrl #(.NUM_TAPS(NUM_TAPS), .NUM_GROUPS(NUM_GROUPS), .SEL_W(SEL_W)) u_window (
        .clk(clk), .rst_n(rst_n), .range_code(range_code), .done(done), .line(line),
        .win_sel(win_sel), .win_taps(win_taps), .grp_en(grp_en)
    );
endmodule

// File: tb/pw_range_ident_test.sv
module pw_range_ident_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_pulse = 1'b0;
    logic [15:0] line = '0;
    logic [3:0]  range_code;
    logic        done, overflow;
    logic [1:0]  win_sel;
    logic [3:0]  win_taps, grp_en;

    int checks = 0;
    int fails  = 0;
    localparam logic [15:0] PROBE = 16'hA5C3;

    always #10 clk = ~clk;

    pw_range_ident uut (
        .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .line(line),
        .range_code(range_code), .done(done), .overflow(overflow),
        .win_sel(win_sel), .win_taps(win_taps), .grp_en(grp_en)
    );

    // Vector: {line, expected range index, expected overflow}
    localparam int NV = 8;
    localparam logic [18:0] VEC [NV] = '{
        {16'h0000, 2'd0, 1'b0},   // never reached tap 4
        {16'h000F, 2'd0, 1'b0},   // stops just short of tap 4
        {16'h001F, 2'd1, 1'b0},   // reaches tap 4
        {16'h01FF, 2'd2, 1'b0},   // reaches tap 8
        {16'h0FFF, 2'd2, 1'b0},   // just short of tap 12
        {16'h1FFF, 2'd3, 1'b0},   // reaches tap 12
        {16'hFFFF, 2'd3, 1'b1},   // whole line: overflow
        {16'h1000, 2'd3, 1'b0}    // non-thermometer: highest tap wins
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; ref_pulse = 1'b0; line = '0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One-cycle pulse; full line driven on the falling cycle (must be ignored, R5).
    task automatic measure(input logic [15:0] l);
        ref_pulse = 1'b1; line = l;
        @(negedge clk);
        ref_pulse = 1'b0; line = 16'hFFFF;
        @(negedge clk);
    endtask

    task automatic check_result(input string tag, input int k, input logic ov);
        logic [4:0] en;
        en = (5'd2 << k) - 5'd1;
        chk({tag, " R2 range"}, range_code, 4'b1000 >> k);
        chk({tag, " R4 done"}, done, 1);
        chk({tag, " R3 overflow"}, overflow, ov);
        chk({tag, " R6 win_sel"}, win_sel, k);
        chk({tag, " R7 grp_en"}, grp_en, en[3:0]);
        chk({tag, " R8 onehot"}, $countones(range_code), 1);
        line = PROBE;
        #1;
        chk({tag, " R6 win_taps"}, win_taps, (PROBE >> (4*k)) & 16'hF);
    endtask

    initial begin
        fork
            begin
                do_reset();
                #1;
                // R1: reset state
                chk("R1 range", range_code, 4'b1000);
                chk("R1 done", done, 0);
                chk("R1 overflow", overflow, 0);
                chk("R1 win_sel", win_sel, 0);
                chk("R1 grp_en", grp_en, 4'hF);

                // Table walk
                for (int i = 0; i < NV; i++) begin
                    do_reset();
                    measure(VEC[i][18:3]);
                    check_result($sformatf("vec%0d", i), int'(VEC[i][2:1]), VEC[i][0]);
                end

                // R5: multi-cycle pulse, last high sample decides
                do_reset();
                ref_pulse = 1'b1; line = 16'h001F;
                @(negedge clk);
                chk("R7 enables during measure", grp_en, 4'hF);
                chk("R4 not done while high", done, 0);
                line = 16'h03FF;
                @(negedge clk);
                ref_pulse = 1'b0; line = 16'h0000;
                @(negedge clk);
                check_result("R5 last sample", 2, 1'b0);

                // R4: second pulse after done is ignored
                measure(16'hFFFF);
                measure(16'h0000);
                check_result("R4 frozen", 2, 1'b0);

                // R1/R4: reset mid-measurement discards partial samples
                do_reset();
                ref_pulse = 1'b1; line = 16'hFFFF;
                @(negedge clk);
                rst_n = 1'b0;
                @(negedge clk);
                ref_pulse = 1'b0; line = '0;
                @(negedge clk);
                rst_n = 1'b1;
                #1;
                chk("R1 range after mid reset", range_code, 4'b1000);
                chk("R1 done after mid reset", done, 0);
                @(negedge clk);
                measure(16'h001F);
                check_result("R2 after mid reset", 1, 1'b0);
            end
            begin
                repeat (5000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule